// File: doc/BRIEF.md
# Multiplexed segment LCD scan controller

This block drives a multiplexed segment LCD with fifteen segment lines and up to four common lines. A simple synchronous register bus writes and reads a small display memory. Each memory byte holds one segment's on/off pattern, one bit per common line. The same bus reaches a mode register, a slot-length divisor, a bias gain selector and a status register. Every panel line is driven as a 3-bit level code. An analog bias stage turns each code into a real voltage. That stage lies outside this block.

Power-up is guarded in hardware. When boost is enabled, a settle counter starts. The lines stay idle until the counter expires. They then go to the deselect (mid) level if deselect output is enabled. The scan starts only when display output is switched on after both conditions hold. Asking for display output too early sets a sticky error flag and leaves the outputs where they are. While the scan runs, one common at a time is selected for one divisor period. The drive polarity flips after every complete frame, so the panel sees no average DC.

Top module: `lcd_seg_ctrl`

## Requirements
- R1: After reset every line carries code 0 (idle), `pump_en` and `bias_gain` are 0, and the mode, divisor, gain and status registers read 0.
- R2: Display bytes sit at addresses 0x00 to 0x0E, and address k belongs to segment k. Bit c of a byte (c = 0..3) is that segment's state during common c. The low nibble reads back as written.
- R3: The upper nibble of each display byte is not stored: it reads 0 whatever was written. Addresses 0x0F and 0x14 to 0x1F read 0.
- R4: The mode register is at 0x10. Bit 7 enables display, bit 6 enables boost, bit 4 enables deselect output, and bit 0 selects 3-common (1) or 4-common (0) scanning. Its other bits read 0. `pump_en` follows bit 6.
- R5: With boost cleared, every line carries code 0 from the clock edge that writes the register. The settle counter restarts from zero.
- R6: Status bit 1 (settled) rises SETTLE_CYCLES clock edges after the edge that sets boost. Before that the lines stay idle. After it, if deselect is enabled and the scan is not running, every line carries code 1 (mid).
- R7: If display enable goes from 0 to 1 while the block is not settled, or while deselect or boost is off, status bit 0 (error) is set and no scan starts. Writing status (0x13) with bit 0 = 1 clears the flag.
- R8: While scanning, each common slot lasts divisor+1 clocks (divisor at 0x11). The commons are selected in order 0,1,2(,3). The selected common carries code 2 in even frames and code 3 in odd frames. All other commons carry code 1.
- R9: While scanning, a segment whose bit for the current common is 1 carries code 4 (even frame) or 5 (odd frame). Otherwise it carries code 6 (even) or 7 (odd).
- R10: Polarity starts even when the scan starts and flips only at the end of each complete frame.
- R11: In 3-common mode a frame has three slots, COM3 stays at code 1, and display bit 3 has no effect.
- R12: Gain register 0x12 bit 0 drives `bias_gain`.
- R13: Status bit 2 reads 1 while the scan is running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Register or display byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read strobe |
| pump_en | output | 1 | Enable for the external voltage boost stage |
| bias_gain | output | 1 | Bias level set selector for the analog stage |
| com_code | output | 12 | Level code per common, 3 bits each, COM0 lowest |
| seg_code | output | 45 | Level code per segment, 3 bits each, S0 lowest |

## Verification
The assertions assume that the bus holds `bus_sel` for exactly one cycle per access and never mixes a read and a write in one cycle. The stimulus meets this by driving each access at a falling edge and removing it at the next falling edge. The assertions also assume that the divisor and the mux mode change only while the scan is stopped. The stimulus drops display output to the deselect state before it changes either one. This keeps slot lengths and polarity flips in line with the frame the bench expects.

// File: rtl/lcd_seg_pkg.sv
package lcd_seg_pkg;

   localparam int CODE_W = 3;

   typedef enum logic [CODE_W-1:0] {
      LC_IDLE      = 3'd0,
      LC_MID       = 3'd1,
      LC_COM_P     = 3'd2,
      LC_COM_N     = 3'd3,
      LC_SEG_ON_P  = 3'd4,
      LC_SEG_ON_N  = 3'd5,
      LC_SEG_OFF_P = 3'd6,
      LC_SEG_OFF_N = 3'd7
   } lvl_code_t;

   typedef enum logic [1:0] {
      DRV_IDLE  = 2'd0,
      DRV_DESEL = 2'd1,
      DRV_SCAN  = 2'd2
   } drv_state_t;

   typedef struct packed {
      logic disp_en;
      logic boost_en;
      logic desel_en;
      logic mux3;
   } mode_t;

   localparam int MODE_DISP_BIT  = 7;
   localparam int MODE_BOOST_BIT = 6;
   localparam int MODE_DESEL_BIT = 4;
   localparam int MODE_MUX_BIT   = 0;

   localparam logic [4:0] ADDR_MODE = 5'h10;
   localparam logic [4:0] ADDR_DIV  = 5'h11;
   localparam logic [4:0] ADDR_GAIN = 5'h12;
   localparam logic [4:0] ADDR_STAT = 5'h13;

endpackage

// File: rtl/lcd_seg_regs.sv
module lcd_seg_regs
   import lcd_seg_pkg::*;
#(
   parameter int NSEG  = 15,
   parameter int NCOM  = 4,
   parameter int DIV_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [4:0]           bus_addr,
   input  logic [7:0]           bus_wdata,
   output logic [7:0]           bus_rdata,
   output mode_t                mode,
   output logic [DIV_W-1:0]     div,
   output logic                 gain,
   output logic                 err_clr,
   input  logic                 err,
   input  logic                 settled,
   input  logic                 running,
   output logic [NSEG*NCOM-1:0] mem_flat
);

   localparam int         SEG_IW  = (NSEG > 1) ? $clog2(NSEG) : 1;
   localparam logic [4:0] SEG_LIM = 5'(NSEG);

   logic wr, rd;
   assign wr = bus_sel &  bus_we;
   assign rd = bus_sel & ~bus_we;

   logic [NCOM-1:0] cell_rd [NSEG];

   // one nibble-wide cell per segment; upper data bits have no storage
   for (genvar i = 0; i < NSEG; i++) begin : g_cell
      logic [NCOM-1:0] cell_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            cell_q <= '0;
         else if (wr && bus_addr == 5'(i))
            cell_q <= bus_wdata[NCOM-1:0];
      end
      assign cell_rd[i]                  = cell_q;
      assign mem_flat[i*NCOM +: NCOM]    = cell_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode <= '0;
         div  <= '0;
         gain <= 1'b0;
      end else if (wr) begin
         case (bus_addr)
            ADDR_MODE: begin
               mode.disp_en  <= bus_wdata[MODE_DISP_BIT];
               mode.boost_en <= bus_wdata[MODE_BOOST_BIT];
               mode.desel_en <= bus_wdata[MODE_DESEL_BIT];
               mode.mux3     <= bus_wdata[MODE_MUX_BIT];
            end
            ADDR_DIV:  div  <= bus_wdata[DIV_W-1:0];
            ADDR_GAIN: gain <= bus_wdata[0];
            default: ;
         endcase
      end
   end

   assign err_clr = wr && (bus_addr == ADDR_STAT) && bus_wdata[0];

   logic [7:0] rd_nxt;
   always_comb begin
      rd_nxt = '0;
      if (bus_addr < SEG_LIM)
         rd_nxt[NCOM-1:0] = cell_rd[bus_addr[SEG_IW-1:0]];
      else begin
         case (bus_addr)
            ADDR_MODE: rd_nxt = {mode.disp_en, mode.boost_en, 1'b0, mode.desel_en,
                                 3'b000, mode.mux3};
            ADDR_DIV:  rd_nxt[DIV_W-1:0] = div;
            ADDR_GAIN: rd_nxt[0] = gain;
            ADDR_STAT: rd_nxt[2:0] = {running, settled, err};
            default:   rd_nxt = '0;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         bus_rdata <= '0;
      else if (rd)
         bus_rdata <= rd_nxt;
   end

   logic unused_wdata;
   assign unused_wdata = ^bus_wdata;

   // R3: a display byte never returns anything above its common bits
   assert_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr < SEG_LIM) |=> (bus_rdata[7:NCOM] == '0));

   // R4: reserved mode bits read back as zero
   assert_mode_reserved_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && bus_addr == ADDR_MODE) |=> (bus_rdata[5] == 1'b0 && bus_rdata[3:1] == 3'b000));

endmodule

// File: rtl/lcd_seg_power.sv
module lcd_seg_power
   import lcd_seg_pkg::*;
#(
   parameter int SETTLE_CYCLES = 62_500_000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       boost_en,
   input  logic       desel_en,
   input  logic       disp_en,
   input  logic       err_clr,
   output logic       settled,
   output logic       err,
   output drv_state_t state,
   output logic       pump_en
);

   localparam int               CNT_W   = $clog2(SETTLE_CYCLES + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SETTLE_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             disp_prev;
   logic             armed;
   logic             disp_rise;
   logic             err_set;

   // settle timer: restarts whenever boost is off
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!boost_en)
         cnt_q <= '0;
      else if (cnt_q != CNT_MAX)
         cnt_q <= cnt_q + 1'b1;
   end

   assign settled   = (cnt_q == CNT_MAX);
   assign disp_rise = disp_en & ~disp_prev;
   assign err_set   = disp_rise & ~(settled & desel_en & boost_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disp_prev <= 1'b0;
         armed     <= 1'b0;
         err       <= 1'b0;
      end else begin
         disp_prev <= disp_en;
         if (!boost_en || !desel_en || !disp_en)
            armed <= 1'b0;
         else if (disp_rise)
            armed <= settled;
         if (err_set)
            err <= 1'b1;
         else if (err_clr)
            err <= 1'b0;
      end
   end

   always_comb begin
      if (!boost_en || !settled || !desel_en)
         state = DRV_IDLE;
      else if (armed && disp_en)
         state = DRV_SCAN;
      else
         state = DRV_DESEL;
   end

   assign pump_en = boost_en;

   // R5: clearing boost restarts the settle timer
   assert_settle_restart_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !boost_en |=> (cnt_q == '0));

   // R7: an early display request raises the error flag
   assert_err_on_early_disp_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_rise && !settled) |=> err);

   // R7: the scan is never armed unless the panel was settled with deselect on
   assert_arm_needs_settle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(armed) |-> ($past(settled) && $past(desel_en)));

endmodule

// File: rtl/lcd_seg_scan.sv
module lcd_seg_scan
   import lcd_seg_pkg::*;
#(
   parameter int NSEG  = 15,
   parameter int NCOM  = 4,
   parameter int DIV_W = 8
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  drv_state_t             state,
   input  logic                   mux3,
   input  logic [DIV_W-1:0]       div,
   input  logic [NSEG*NCOM-1:0]   mem_flat,
   output logic [NCOM*CODE_W-1:0] com_code,
   output logic [NSEG*CODE_W-1:0] seg_code
);

   localparam int                SLOT_W = $clog2(NCOM);
   localparam logic [SLOT_W-1:0] LAST_F = SLOT_W'(NCOM - 1);
   localparam logic [SLOT_W-1:0] LAST_R = SLOT_W'(NCOM - 2);

   logic              run;
   logic [DIV_W-1:0]  pre_q;
   logic [SLOT_W-1:0] slot_q;
   logic [SLOT_W-1:0] last_slot;
   logic              pol_q;

   assign run       = (state == DRV_SCAN);
   assign last_slot = mux3 ? LAST_R : LAST_F;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q  <= '0;
         slot_q <= '0;
         pol_q  <= 1'b0;
      end else if (!run) begin
         pre_q  <= '0;
         slot_q <= '0;
         pol_q  <= 1'b0;
      end else if (pre_q == div) begin
         pre_q <= '0;
         if (slot_q >= last_slot) begin
            slot_q <= '0;
            pol_q  <= ~pol_q;
         end else
            slot_q <= slot_q + 1'b1;
      end else
         pre_q <= pre_q + 1'b1;
   end

   logic [NCOM-1:0] com_sel;

   for (genvar c = 0; c < NCOM; c++) begin : g_com
      lvl_code_t code;
      always_comb begin
         case (state)
            DRV_SCAN: begin
               if (mux3 && c == NCOM - 1)
                  code = LC_MID;
               else if (slot_q == SLOT_W'(c))
                  code = pol_q ? LC_COM_N : LC_COM_P;
               else
                  code = LC_MID;
            end
            DRV_DESEL: code = LC_MID;
            default:   code = LC_IDLE;
         endcase
      end
      assign com_code[c*CODE_W +: CODE_W] = code;
      assign com_sel[c] = (com_code[c*CODE_W +: CODE_W] == LC_COM_P) ||
                          (com_code[c*CODE_W +: CODE_W] == LC_COM_N);
   end

   for (genvar s = 0; s < NSEG; s++) begin : g_seg
      logic [NCOM-1:0] bits;
      logic            on;
      lvl_code_t       code;
      assign bits = mem_flat[s*NCOM +: NCOM];
      assign on   = bits[slot_q] & ~(mux3 && slot_q == LAST_F);
      always_comb begin
         case (state)
            DRV_SCAN:  code = on ? (pol_q ? LC_SEG_ON_N  : LC_SEG_ON_P)
                                 : (pol_q ? LC_SEG_OFF_N : LC_SEG_OFF_P);
            DRV_DESEL: code = LC_MID;
            default:   code = LC_IDLE;
         endcase
      end
      assign seg_code[s*CODE_W +: CODE_W] = code;
   end

   // R8: exactly one common carries a select code while scanning
   assert_one_common_R8: assert property (@(posedge clk) disable iff (!rst_n)
      run |-> ($countones(com_sel) == 1));

   // R8: outside the scan no common is selected
   assert_no_select_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> $onehot0(com_sel) && (com_sel == '0));

   // R10: polarity only flips as the last slot of a frame ends
   assert_pol_flip_at_frame_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $past(run) && !$stable(pol_q)) |->
         ($past(slot_q) == $past(last_slot) && $past(pre_q) == $past(div)));

   // R11: the fourth common rests at mid level in 3-common mode
   assert_com3_mid_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (run && mux3) |-> (com_code[(NCOM-1)*CODE_W +: CODE_W] == LC_MID));

   // R5: idle state drives idle code on every line
   assert_idle_lines_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (state == DRV_IDLE) |-> (com_code == '0 && seg_code == '0));

endmodule

// File: rtl/lcd_seg_ctrl.sv
module lcd_seg_ctrl
   import lcd_seg_pkg::*;
#(
   parameter int NSEG          = 15,
   parameter int NCOM          = 4,
   parameter int DIV_W         = 8,
   parameter int SETTLE_CYCLES = 62_500_000
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   bus_sel,
   input  logic                   bus_we,
   input  logic [4:0]             bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   output logic                   pump_en,
   output logic                   bias_gain,
   output logic [NCOM*CODE_W-1:0] com_code,
   output logic [NSEG*CODE_W-1:0] seg_code
);

   if (NSEG < 1 || NSEG > 16) begin : g_bad_nseg
      $error("NSEG must lie in 1..16");
   end
   if (NCOM < 2 || NCOM > 8) begin : g_bad_ncom
      $error("NCOM must lie in 2..8");
   end
   if (DIV_W < 1 || DIV_W > 8) begin : g_bad_div
      $error("DIV_W must lie in 1..8");
   end
   if (SETTLE_CYCLES < 1) begin : g_bad_settle
      $error("SETTLE_CYCLES must be at least 1");
   end

   mode_t                mode;
   logic [DIV_W-1:0]     div;
   logic                 err_clr;
   logic                 err;
   logic                 settled;
   drv_state_t           state;
   logic [NSEG*NCOM-1:0] mem_flat;
   logic                 running;

   assign running = (state == DRV_SCAN);

   lcd_seg_regs #(.NSEG(NSEG), .NCOM(NCOM), .DIV_W(DIV_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_we    (bus_we),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .mode      (mode),
      .div       (div),
      .gain      (bias_gain),
      .err_clr   (err_clr),
      .err       (err),
      .settled   (settled),
      .running   (running),
      .mem_flat  (mem_flat)
   );

   lcd_seg_power #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_power (
      .clk      (clk),
      .rst_n    (rst_n),
      .boost_en (mode.boost_en),
      .desel_en (mode.desel_en),
      .disp_en  (mode.disp_en),
      .err_clr  (err_clr),
      .settled  (settled),
      .err      (err),
      .state    (state),
      .pump_en  (pump_en)
   );

   lcd_seg_scan #(.NSEG(NSEG), .NCOM(NCOM), .DIV_W(DIV_W)) u_scan (
      .clk      (clk),
      .rst_n    (rst_n),
      .state    (state),
      .mux3     (mode.mux3),
      .div      (div),
      .mem_flat (mem_flat),
      .com_code (com_code),
      .seg_code (seg_code)
   );

endmodule

// File: tb/lcd_seg_ctrl_test.sv
module lcd_seg_ctrl_test;

   localparam int SETTLE = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [7:0]  bus_wdata = '0;
   logic [7:0]  bus_rdata;
   logic        pump_en;
   logic        bias_gain;
   logic [11:0] com_code;
   logic [44:0] seg_code;

   int n_chk = 0;
   int n_err = 0;
   logic [3:0] sh [15];

   always #4 clk = ~clk;

   lcd_seg_ctrl #(.SETTLE_CYCLES(SETTLE)) uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .pump_en(pump_en), .bias_gain(bias_gain),
      .com_code(com_code), .seg_code(seg_code)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   function automatic logic [2:0] exp_com(int c, int s, bit pol, bit m3);
      if (m3 && c == 3) return 3'd1;
      if (c == s) return pol ? 3'd3 : 3'd2;
      return 3'd1;
   endfunction

   function automatic logic [2:0] exp_seg(bit on, bit pol);
      if (on) return pol ? 3'd5 : 3'd4;
      return pol ? 3'd7 : 3'd6;
   endfunction

   task automatic chk_all(input string req, input logic [2:0] code);
      logic [11:0] ce;
      logic [44:0] se;
      for (int i = 0; i < 4; i++)  ce[i*3 +: 3] = code;
      for (int j = 0; j < 15; j++) se[j*3 +: 3] = code;
      chk(req, com_code, ce);
      chk(req, seg_code, se);
   endtask

   // called at the falling edge where slot 0 of the first frame is visible
   task automatic check_frames(input string req, input bit m3, input int dv);
      int ns;
      ns = m3 ? 3 : 4;
      for (int f = 0; f < 2; f++) begin
         for (int s = 0; s < ns; s++) begin
            logic [11:0] ce;
            logic [44:0] se;
            for (int i = 0; i < 4; i++)  ce[i*3 +: 3] = exp_com(i, s, f[0], m3);
            for (int j = 0; j < 15; j++) se[j*3 +: 3] = exp_seg(sh[j][s], f[0]);
            chk(req, com_code, ce);
            chk(req, seg_code, se);
            repeat (dv + 1) @(posedge clk);
            @(negedge clk);
         end
      end
   endtask

   task automatic t_reset();
      logic [7:0] d;
      chk_all("R1 idle lines", 3'd0);
      chk("R1 pump", pump_en, 0);
      chk("R1 gain", bias_gain, 0);
      bus_rd(5'h10, d); chk("R1 mode", d, 8'h00);
      bus_rd(5'h11, d); chk("R1 div", d, 8'h00);
      bus_rd(5'h13, d); chk("R1 status", d, 8'h00);
   endtask

   task automatic t_memory();
      logic [7:0] d;
      for (int j = 0; j < 15; j++) begin
         sh[j] = 4'((j * 5 + 9) % 16);
         bus_wr(5'(j), {4'(15 - j), sh[j]});
      end
      for (int j = 0; j < 15; j++) begin
         bus_rd(5'(j), d);
         chk("R2 low nibble", d[3:0], sh[j]);
         chk("R3 upper nibble", d[7:4], 4'h0);
      end
      bus_wr(5'h0F, 8'hFF);
      bus_rd(5'h0F, d); chk("R3 hole 0x0F", d, 8'h00);
      bus_rd(5'h1F, d); chk("R3 hole 0x1F", d, 8'h00);
   endtask

   task automatic t_mode_gain();
      logic [7:0] d;
      bus_wr(5'h10, 8'h2E);
      bus_rd(5'h10, d); chk("R4 reserved bits", d, 8'h00);
      chk("R4 pump off", pump_en, 0);
      bus_wr(5'h12, 8'h01);
      chk("R12 gain pin", bias_gain, 1);
      bus_rd(5'h12, d); chk("R12 gain read", d, 8'h01);
      bus_wr(5'h12, 8'h00);
      chk("R12 gain pin low", bias_gain, 0);
      bus_wr(5'h11, 8'h02);
   endtask

   task automatic t_interlock();
      logic [7:0] d;
      bus_wr(5'h10, 8'hD0);
      chk("R4 pump follows boost", pump_en, 1);
      bus_rd(5'h13, d); chk("R7 error early", d, 8'h01);
      chk_all("R7 lines idle", 3'd0);
      bus_rd(5'h10, d); chk("R4 mode read", d, 8'hD0);
      bus_wr(5'h13, 8'h01);
      bus_rd(5'h13, d); chk("R7 error cleared", d[0], 1'b0);
      bus_wr(5'h10, 8'h40);
      repeat (SETTLE + 10) @(posedge clk);
      bus_rd(5'h13, d); chk("R6 settled flag", d, 8'h02);
      bus_wr(5'h10, 8'hC0);
      chk_all("R7 no deselect lines idle", 3'd0);
      bus_rd(5'h13, d); chk("R7 error no deselect", d, 8'h03);
      bus_wr(5'h13, 8'h01);
   endtask

   task automatic t_bringup();
      bus_wr(5'h10, 8'h00);
      chk_all("R5 boost off idle", 3'd0);
      chk("R5 pump off", pump_en, 0);
      bus_wr(5'h10, 8'h50);
      repeat (SETTLE - 1) @(posedge clk);
      @(negedge clk);
      chk_all("R6 idle before settle", 3'd0);
      @(posedge clk);
      @(negedge clk);
      chk_all("R6 mid after settle", 3'd1);
   endtask

   task automatic t_scan4();
      logic [7:0] d;
      bus_wr(5'h10, 8'hD0);
      @(posedge clk);
      @(negedge clk);
      check_frames("R8 R9 R10 four-common scan", 1'b0, 2);
      bus_rd(5'h13, d); chk("R13 running flag", d, 8'h06);
   endtask

   task automatic t_scan3();
      bus_wr(5'h10, 8'h51);
      chk_all("R6 back to mid", 3'd1);
      bus_wr(5'h11, 8'h03);
      bus_wr(5'h10, 8'hD1);
      @(posedge clk);
      @(negedge clk);
      check_frames("R11 R8 three-common scan", 1'b1, 3);
   endtask

   task automatic t_boost_off();
      logic [7:0] d;
      bus_wr(5'h10, 8'h00);
      chk_all("R5 scan stopped idle", 3'd0);
      chk("R5 pump off again", pump_en, 0);
      bus_wr(5'h10, 8'h40);
      bus_rd(5'h13, d); chk("R5 settle restarted", d, 8'h00);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_memory();
      t_mode_gain();
      t_interlock();
      t_bringup();
      t_scan4();
      t_scan3();
      t_boost_off();
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

endmodule